// File: doc/BRIEF.md
# Per-CPU Register Frame Access Decoder

This block sits between a memory-mapped bus and a row of per-CPU register banks. Each incoming access carries an address, a byte count, a write flag, a security attribute and write data. The upper address bits pick the CPU whose frame is addressed and the lower bits give the offset inside that frame. The decoder checks the access width against what the addressed location allows, then forwards legal accesses to exactly one bank over a 64-bit lane with byte enables. The bank's lane read data is narrowed back to the access width.

Registers that are 64 bits wide can be reached as one doubleword or as two word halves at +0 and +4. A word half maps onto the matching four bytes of the lane, so a half write touches only its own half. An access that breaks a rule never reaches a bank. It still completes normally, with zero read data and a guest-error flag on the response. The decoder answers every access exactly one cycle later and never stalls.

Top module: `frame_decoder`

## Requirements
- R1: The CPU index is the address divided by FRAME_BYTES (0x20000) and the local offset is the remainder. A legal access raises only `bank_req[index]`. `bank_addr` is the local offset with its three low bits cleared.
- R2: Every cycle with `req_valid` high is followed, on the next cycle, by exactly one cycle of `rsp_valid`. `rsp_valid` is low in every other cycle.
- R3: A word access whose offset is not a multiple of 4, or a doubleword access whose offset is not a multiple of 8, is invalid.
- R4: A byte access (`req_size`=1) is legal only when the local offset is in [PRIO_OFF, PRIO_OFF+32), with PRIO_OFF = 0x10400 by default. Its byte enable is bit offset[2:0], and `rsp_rdata` is that lane byte, zero-extended.
- R5: An aligned word access (`req_size`=4) is legal at any local offset. Offset bit 2 = 0 gives `bank_be`=0x0F and the low lane half; bit 2 = 1 gives `bank_be`=0xF0 and the high lane half. The write data sits in the enabled bytes, and read data is the selected half, zero-extended.
- R6: A doubleword access (`req_size`=8) is legal only at local offsets 0x08, 0x70 and 0x78. It uses `bank_be`=0xFF and the full 64-bit data.
- R7: A `req_size` value other than 1, 4 or 8 (byte counts) makes the access invalid.
- R8: A CPU index at or above NCPU (4 by default) makes the access invalid.
- R9: An invalid access raises no `bank_req` and completes with `rsp_err`=1 and `rsp_rdata`=0. A legal access completes with `rsp_err`=0.
- R10: A write access returns `rsp_rdata`=0.
- R11: During reset and on the first cycle after it, `rsp_valid` and `rsp_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access present this cycle |
| req_addr | input | ADDR_W (20) | Byte address across all frames |
| req_size | input | 4 | Access size in bytes |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Security attribute, passed to the bank |
| req_wdata | input | 64 | Write data, right-aligned |
| bank_req | output | NCPU | One-hot bank select |
| bank_write | output | 1 | Write flag to the banks |
| bank_secure | output | 1 | Security attribute to the banks |
| bank_addr | output | FRAME_W (17) | Lane-aligned local offset |
| bank_be | output | 8 | Byte enables on the 64-bit lane |
| bank_wdata | output | 64 | Lane-placed write data |
| bank_rdata | input | NCPU*64 | Lane read data, bank c at bits [c*64 +: 64] |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | 64 | Read data, narrowed to the access size |
| rsp_err | output | 1 | Guest-error flag for an invalid access |

## Verification
The assertions check, on every cycle, the rules that link one cycle to the next: the one-cycle response, the one-hot bank select, zero data on errors and writes, and an error after any request that reached no bank. They also check the full lane for doubleword accesses. Only the bench's scenarios can show that the right rule applies to a given offset and width. That covers the edges of the byte window, the three doubleword offsets, lane placement for each half, and the CPU-index limit, which it checks against data patterns it computes itself.

// File: rtl/frame_decoder_pkg.sv
package frame_decoder_pkg;

    typedef enum logic [1:0] {
        W_BAD  = 2'd0,
        W_BYTE = 2'd1,
        W_WORD = 2'd2,
        W_DBL  = 2'd3
    } width_e;

    typedef struct packed {
        logic        valid;
        logic        err;
        logic [63:0] rdata;
    } rsp_t;

    function automatic width_e size_to_width(input logic [3:0] sz);
        case (sz)
            4'd1:    return W_BYTE;
            4'd4:    return W_WORD;
            4'd8:    return W_DBL;
            default: return W_BAD;
        endcase
    endfunction

endpackage

// File: rtl/fd_route.sv
module fd_route #(
    parameter int ADDR_W  = 20,
    parameter int FRAME_W = 17,
    parameter int NCPU    = 4
) (
    input  logic [ADDR_W-1:0]         addr,
    output logic [ADDR_W-FRAME_W-1:0] cpu_idx,
    output logic [FRAME_W-1:0]        local_off,
    output logic                      cpu_ok
);
    localparam int IDX_W = ADDR_W - FRAME_W;

    always_comb begin
        cpu_idx   = addr[ADDR_W-1:FRAME_W];
        local_off = addr[FRAME_W-1:0];
        cpu_ok    = ({1'b0, cpu_idx} < (IDX_W+1)'(NCPU));
    end
endmodule

// File: rtl/fd_legal.sv
module fd_legal
    import frame_decoder_pkg::*;
#(
    parameter int FRAME_W    = 17,
    parameter int PRIO_OFF   = 'h10400,
    parameter int PRIO_BYTES = 32,
    parameter int TYPE_OFF   = 'h08,
    parameter int PBASE_OFF  = 'h70,
    parameter int QBASE_OFF  = 'h78
) (
    input  width_e             width,
    input  logic [FRAME_W-1:0] local_off,
    input  logic               cpu_ok,
    output logic               legal
);
    localparam int             FW      = FRAME_W + 1;
    localparam logic [FW-1:0]  PRIO_LO = FW'(PRIO_OFF);
    localparam logic [FW-1:0]  PRIO_HI = FW'(PRIO_OFF + PRIO_BYTES);
    localparam logic [FRAME_W-1:0] TYPE_L  = FRAME_W'(TYPE_OFF);
    localparam logic [FRAME_W-1:0] PBASE_L = FRAME_W'(PBASE_OFF);
    localparam logic [FRAME_W-1:0] QBASE_L = FRAME_W'(QBASE_OFF);

    logic [FW-1:0] off_ext;
    logic          in_prio;
    logic          dbl_reg;

    always_comb begin
        off_ext = {1'b0, local_off};
        in_prio = (off_ext >= PRIO_LO) && (off_ext < PRIO_HI);
        dbl_reg = (local_off == TYPE_L) || (local_off == PBASE_L) ||
                  (local_off == QBASE_L);
        case (width)
            W_BYTE:  legal = in_prio;
            W_WORD:  legal = (local_off[1:0] == 2'b00);
            W_DBL:   legal = (local_off[2:0] == 3'b000) && dbl_reg;
            default: legal = 1'b0;
        endcase
        legal = legal && cpu_ok;
    end
endmodule

// File: rtl/fd_lane.sv
module fd_lane
    import frame_decoder_pkg::*;
(
    input  width_e      width,
    input  logic [2:0]  lane_off,
    input  logic [63:0] wdata,
    input  logic [63:0] lane_rd,
    output logic [7:0]  be,
    output logic [63:0] lane_wd,
    output logic [63:0] rd_out
);
    logic [63:0] shifted;

    always_comb begin
        shifted = lane_rd >> {lane_off, 3'b000};
        case (width)
            W_BYTE: begin
                be      = 8'h01 << lane_off;
                lane_wd = {8{wdata[7:0]}};
                rd_out  = {56'h0, shifted[7:0]};
            end
            W_WORD: begin
                be      = lane_off[2] ? 8'hF0 : 8'h0F;
                lane_wd = {2{wdata[31:0]}};
                rd_out  = {32'h0, shifted[31:0]};
            end
            W_DBL: begin
                be      = 8'hFF;
                lane_wd = wdata;
                rd_out  = lane_rd;
            end
            default: begin
                be      = 8'h00;
                lane_wd = 64'h0;
                rd_out  = 64'h0;
            end
        endcase
    end
endmodule

// File: rtl/frame_decoder.sv
module frame_decoder
    import frame_decoder_pkg::*;
#(
    parameter int NCPU        = 4,
    parameter int FRAME_BYTES = 'h20000,
    parameter int ADDR_W      = 20,
    parameter int PRIO_OFF    = 'h10400,
    parameter int PRIO_BYTES  = 32,
    parameter int TYPE_OFF    = 'h08,
    parameter int PBASE_OFF   = 'h70,
    parameter int QBASE_OFF   = 'h78,
    localparam int FRAME_W    = $clog2(FRAME_BYTES),
    localparam int IDX_W      = ADDR_W - FRAME_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [3:0]           req_size,
    input  logic                 req_write,
    input  logic                 req_secure,
    input  logic [63:0]          req_wdata,
    output logic [NCPU-1:0]      bank_req,
    output logic                 bank_write,
    output logic                 bank_secure,
    output logic [FRAME_W-1:0]   bank_addr,
    output logic [7:0]           bank_be,
    output logic [63:0]          bank_wdata,
    input  logic [NCPU*64-1:0]   bank_rdata,
    output logic                 rsp_valid,
    output logic [63:0]          rsp_rdata,
    output logic                 rsp_err
);
    width_e             width;
    logic [IDX_W-1:0]   cpu_idx;
    logic [FRAME_W-1:0] local_off;
    logic               cpu_ok;
    logic               legal;
    logic [63:0]        lane_rd;
    logic [63:0]        narrow_rd;
    rsp_t               rsp_d, rsp_q;

    assign width = size_to_width(req_size);

    fd_route #(.ADDR_W(ADDR_W), .FRAME_W(FRAME_W), .NCPU(NCPU)) u_route (
        .addr(req_addr), .cpu_idx(cpu_idx), .local_off(local_off), .cpu_ok(cpu_ok)
    );

    fd_legal #(
        .FRAME_W(FRAME_W), .PRIO_OFF(PRIO_OFF), .PRIO_BYTES(PRIO_BYTES),
        .TYPE_OFF(TYPE_OFF), .PBASE_OFF(PBASE_OFF), .QBASE_OFF(QBASE_OFF)
    ) u_legal (
        .width(width), .local_off(local_off), .cpu_ok(cpu_ok), .legal(legal)
    );

    fd_lane u_lane (
        .width(width), .lane_off(local_off[2:0]), .wdata(req_wdata),
        .lane_rd(lane_rd), .be(bank_be), .lane_wd(bank_wdata), .rd_out(narrow_rd)
    );

    generate
        for (genvar c = 0; c < NCPU; c++) begin : g_sel
            assign bank_req[c] = req_valid && legal && (cpu_idx == IDX_W'(c));
        end
    endgenerate

    always_comb begin
        lane_rd = 64'h0;
        for (int c = 0; c < NCPU; c++) begin
            if (bank_req[c]) lane_rd = bank_rdata[c*64 +: 64];
        end
    end

    assign bank_write  = req_write;
    assign bank_secure = req_secure;
    assign bank_addr   = {local_off[FRAME_W-1:3], 3'b000};

    always_comb begin
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        rsp_d.err   = req_valid && !legal;
        if (req_valid && legal && !req_write) rsp_d.rdata = narrow_rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    p_one_cycle_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    p_no_idle_rsp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    p_bank_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_req));
    p_unrouted_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bank_req == '0) |=> rsp_err);
    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_valid && rsp_rdata == 64'h0));
    p_write_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 64'h0));
    p_dbl_lane_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_req != '0 && req_size == 4'd8) |-> (bank_be == 8'hFF));
endmodule

// File: tb/sim_frame_decoder.sv
module sim_frame_decoder;
    localparam int NCPU = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [19:0]        req_addr = '0;
    logic [3:0]         req_size = '0;
    logic               req_write = 1'b0;
    logic               req_secure = 1'b0;
    logic [63:0]        req_wdata = '0;
    logic [NCPU-1:0]    bank_req;
    logic               bank_write, bank_secure;
    logic [16:0]        bank_addr;
    logic [7:0]         bank_be;
    logic [63:0]        bank_wdata;
    logic [NCPU*64-1:0] bank_rdata;
    logic               rsp_valid, rsp_err;
    logic [63:0]        rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [NCPU-1:0] ob_req;
    logic [7:0]      ob_be;
    logic [16:0]     ob_addr;
    logic [63:0]     ob_wd;
    logic            or_v, or_e;
    logic [63:0]     or_d;

    always #10 clk = ~clk;

    frame_decoder u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_secure(req_secure),
        .req_wdata(req_wdata), .bank_req(bank_req), .bank_write(bank_write),
        .bank_secure(bank_secure), .bank_addr(bank_addr), .bank_be(bank_be),
        .bank_wdata(bank_wdata), .bank_rdata(bank_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
    );

    function automatic logic [63:0] pat(input int c, input logic [16:0] a);
        return {12'hC00, 4'(c), 15'h0, a, 16'h5A5A};
    endfunction

    always_comb begin
        for (int c = 0; c < NCPU; c++) bank_rdata[c*64 +: 64] = pat(c, bank_addr);
    end

    task automatic check(input logic ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic [3:0] sz, input logic [19:0] a,
                       input logic wr, input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_size = sz; req_addr = a; req_write = wr; req_wdata = wd;
        #2;
        ob_req = bank_req; ob_be = bank_be; ob_addr = bank_addr; ob_wd = bank_wdata;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        or_v = rsp_valid; or_e = rsp_err; or_d = rsp_rdata;
    endtask

    task automatic expect_ok(input string tag, input int cpu, input logic [16:0] ba,
                             input logic [7:0] be, input logic [63:0] rd);
        check(ob_req == NCPU'(1 << cpu), {tag, " R1 bank select"}, 64'(ob_req), 64'(1 << cpu));
        check(ob_addr == ba, {tag, " R1 bank addr"}, 64'(ob_addr), 64'(ba));
        check(ob_be == be, {tag, " byte enables"}, 64'(ob_be), 64'(be));
        check(or_v && !or_e, {tag, " R9 ok response"}, {62'h0, or_v, or_e}, 64'h2);
        check(or_d == rd, {tag, " read data"}, or_d, rd);
    endtask

    task automatic expect_bad(input string tag);
        check(ob_req == '0, {tag, " R9 no bank"}, 64'(ob_req), 64'h0);
        check(or_v && or_e, {tag, " R9 err flag"}, {62'h0, or_v, or_e}, 64'h3);
        check(or_d == 64'h0, {tag, " R9 zero data"}, or_d, 64'h0);
    endtask

    task automatic t_reset_r11;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(!rsp_valid && !rsp_err, "R11 in reset", {62'h0, rsp_valid, rsp_err}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !rsp_err, "R11 after reset", {62'h0, rsp_valid, rsp_err}, 64'h0);
    endtask

    task automatic t_words_r5;
        logic [63:0] p;
        p = pat(1, 17'h100);
        acc(4'd4, 20'h20100, 1'b0, 64'h0);
        expect_ok("R5 low word", 1, 17'h100, 8'h0F, {32'h0, p[31:0]});
        acc(4'd4, 20'h20104, 1'b0, 64'h0);
        expect_ok("R5 high word", 1, 17'h100, 8'hF0, {32'h0, p[63:32]});
        @(negedge clk);
        check(!rsp_valid, "R2 idle after response", 64'(rsp_valid), 64'h0);
    endtask

    task automatic t_dbl_r6;
        acc(4'd8, 20'h60008, 1'b0, 64'h0);
        expect_ok("R6 dword read", 3, 17'h8, 8'hFF, pat(3, 17'h8));
        acc(4'd8, 20'h00070, 1'b1, 64'h1122334455667788);
        expect_ok("R6 dword write", 0, 17'h70, 8'hFF, 64'h0);
        check(ob_wd == 64'h1122334455667788, "R6 dword wdata", ob_wd, 64'h1122334455667788);
        acc(4'd4, 20'h4007C, 1'b1, 64'hAAAA_BBBB_DEAD_BEEF);
        expect_ok("R10 half write", 2, 17'h78, 8'hF0, 64'h0);
        check(ob_wd[63:32] == 32'hDEADBEEF, "R5 upper half wdata",
              64'(ob_wd[63:32]), 64'hDEADBEEF);
        acc(4'd8, 20'h00074, 1'b0, 64'h0);
        expect_bad("R3 dword misaligned");
        acc(4'd8, 20'h00100, 1'b0, 64'h0);
        expect_bad("R6 dword other offset");
    endtask

    task automatic t_bytes_r4;
        logic [63:0] p;
        p = pat(0, 17'h10400);
        acc(4'd1, 20'h10405, 1'b0, 64'h0);
        expect_ok("R4 prio byte 5", 0, 17'h10400, 8'h20, {56'h0, p[47:40]});
        p = pat(0, 17'h10418);
        acc(4'd1, 20'h1041F, 1'b0, 64'h0);
        expect_ok("R4 last prio byte", 0, 17'h10418, 8'h80, {56'h0, p[63:56]});
        acc(4'd1, 20'h10403, 1'b1, 64'h77);
        expect_ok("R4 prio byte write", 0, 17'h10400, 8'h08, 64'h0);
        check(ob_wd[31:24] == 8'h77, "R4 byte wdata", 64'(ob_wd[31:24]), 64'h77);
        acc(4'd1, 20'h10420, 1'b0, 64'h0);
        expect_bad("R4 past window");
        acc(4'd1, 20'h103FF, 1'b0, 64'h0);
        expect_bad("R4 before window");
        acc(4'd1, 20'h00100, 1'b1, 64'hFF);
        expect_bad("R4 write outside window");
    endtask

    task automatic t_sizes_r7;
        acc(4'd2, 20'h00100, 1'b0, 64'h0);
        expect_bad("R7 size 2");
        acc(4'd0, 20'h00100, 1'b0, 64'h0);
        expect_bad("R7 size 0");
        acc(4'd3, 20'h00100, 1'b1, 64'h5);
        expect_bad("R7 size 3");
        acc(4'd4, 20'h00102, 1'b0, 64'h0);
        expect_bad("R3 word misaligned");
    endtask

    task automatic t_cpu_limit_r8;
        acc(4'd4, 20'h80000, 1'b0, 64'h0);
        expect_bad("R8 cpu 4");
        acc(4'd4, 20'hA0100, 1'b1, 64'h1);
        expect_bad("R8 cpu 5");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_r11();
        t_words_r5();
        t_dbl_r6();
        t_bytes_r4();
        t_sizes_r7();
        t_cpu_limit_r8();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule